// File: doc/BRIEF.md
# Link Identifier Capture Register

This block is a 16-bit read-only identification word for the receiving end of a serial optical link. After power-up it reads zero. The link layer reports when the link is initialized. A reset command from the timing interface then latches an identifier. The identifier joins two numbers: a link number wired in hardware and a crate number that the remote sender configured. Every later reset command that arrives on a ready link replaces the latched value with the current inputs.

For loopback testing the word changes layout. The top bit is set to mark the test layout. The low bits then carry the muon index and the device index that the test supplies. The latched identifier is kept while loopback mode is on, and it reads back again when the mode ends. The link protocol itself is handled elsewhere.

Top module: `link_id_reg`

## Requirements
- R1: After reset, with loopback mode off, the read word is 16'h0000 until the first capture.
- R2: A capture takes place on each rising clock edge at which both the command strobe and the link-ready flag are high. The new value shows on the read bus right after that edge.
- R3: In normal mode, bits [1:0] hold the captured hardwired link number (0 to 3).
- R4: In normal mode, bits [7:2] hold the captured crate number (0 to 63).
- R5: In normal mode, bits [15:8] read as zero.
- R6: While the loopback flag is high, bit 15 reads 1, bits [1:0] show the muon index, bits [4:2] show the device index, and bits [14:5] read 0. The word follows these inputs without a clock delay.
- R7: A command strobe that arrives while the link-ready flag is low leaves the captured identifier unchanged.
- R8: A later valid command overwrites the earlier capture with the link and crate numbers present at that edge.
- R9: Captures also take place while loopback mode is on. The latched identifier reads back once the loopback flag drops.
- R10: Changes on the crate or link inputs without a valid command leave the read word unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| link_ready_i | input | 1 | Link has completed initialization |
| reset_cmd_i | input | 1 | Reset-command strobe from the timing interface |
| crate_num_i | input | 6 | Crate number received from the remote sender |
| link_num_i | input | 2 | Hardwired link number |
| loopback_i | input | 1 | Loopback test mode select |
| muon_idx_i | input | 2 | Muon index for the loopback layout |
| dev_idx_i | input | 3 | Device index for the loopback layout |
| rdata_o | output | 16 | Read data word |

## Verification
On every cycle the assertions check four things: the capture rule, that the identifier holds without a qualified command, the zero upper byte in normal mode, and the flag bit and field placement of the loopback layout. Other behaviour shows only across the bench's scenarios. One case is a command that is refused while the link is down, followed by a fresh overwrite. Another is a capture made during loopback that reappears after the mode ends. Random traffic on the crate and link inputs with no command must not disturb the word.

// File: rtl/link_id_pkg.sv
package link_id_pkg;
    parameter int unsigned DATA_W  = 16;
    parameter int unsigned LINK_W  = 2;
    parameter int unsigned CRATE_W = 6;
    parameter int unsigned MUON_W  = 2;
    parameter int unsigned DEV_W   = 3;

    localparam int unsigned ID_W = LINK_W + CRATE_W;

    typedef struct packed {
        logic [CRATE_W-1:0] crate;
        logic [LINK_W-1:0]  link;
    } link_id_t;

    typedef struct packed {
        link_id_t id;
    } cap_state_t;
endpackage

// File: rtl/link_id_capture.sv
module link_id_capture
    import link_id_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               link_ready_i,
    input  logic               reset_cmd_i,
    input  logic [CRATE_W-1:0] crate_num_i,
    input  logic [LINK_W-1:0]  link_num_i,
    output link_id_t           id_o
);
    cap_state_t st_d, st_q;
    logic       take;

    always_comb begin
        st_d = st_q;
        take = reset_cmd_i && link_ready_i;
        if (take) begin
            st_d.id.crate = crate_num_i;
            st_d.id.link  = link_num_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign id_o = st_q.id;

    // R2 / R8: a qualified command loads the present inputs
    p_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (reset_cmd_i && link_ready_i) |=> (id_o == {$past(crate_num_i), $past(link_num_i)}));

    // R7 / R10: without a qualified command the identifier holds
    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(reset_cmd_i && link_ready_i) |=> $stable(id_o));
endmodule

// File: rtl/link_id_format.sv
module link_id_format
    import link_id_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              loopback_i,
    input  logic [MUON_W-1:0] muon_idx_i,
    input  logic [DEV_W-1:0]  dev_idx_i,
    input  link_id_t          id_i,
    output logic [DATA_W-1:0] rdata_o
);
    localparam int unsigned LB_W = MUON_W + DEV_W;

    logic [DATA_W-1:0] norm_word, lb_word;

    always_comb begin
        norm_word           = '0;
        norm_word[ID_W-1:0] = id_i;
        lb_word             = '0;
        lb_word[DATA_W-1]   = 1'b1;
        lb_word[LB_W-1:0]   = {dev_idx_i, muon_idx_i};
        rdata_o             = loopback_i ? lb_word : norm_word;
    end

    // R5: normal layout keeps the upper byte clear
    p_upper_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !loopback_i |-> (rdata_o[DATA_W-1:ID_W] == '0));

    // R6: loopback layout flags itself and places the indices
    p_loop_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
        loopback_i |-> (rdata_o[DATA_W-1] && rdata_o[MUON_W-1:0] == muon_idx_i
                        && rdata_o[LB_W-1:MUON_W] == dev_idx_i
                        && rdata_o[DATA_W-2:LB_W] == '0));
endmodule

// File: rtl/link_id_reg.sv
module link_id_reg
    import link_id_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               link_ready_i,
    input  logic               reset_cmd_i,
    input  logic [CRATE_W-1:0] crate_num_i,
    input  logic [LINK_W-1:0]  link_num_i,
    input  logic               loopback_i,
    input  logic [MUON_W-1:0]  muon_idx_i,
    input  logic [DEV_W-1:0]   dev_idx_i,
    output logic [DATA_W-1:0]  rdata_o
);
    link_id_t id_q;

    link_id_capture u_cap (
        .clk          (clk),
        .rst_n        (rst_n),
        .link_ready_i (link_ready_i),
        .reset_cmd_i  (reset_cmd_i),
        .crate_num_i  (crate_num_i),
        .link_num_i   (link_num_i),
        .id_o         (id_q)
    );

    link_id_format u_fmt (
        .clk        (clk),
        .rst_n      (rst_n),
        .loopback_i (loopback_i),
        .muon_idx_i (muon_idx_i),
        .dev_idx_i  (dev_idx_i),
        .id_i       (id_q),
        .rdata_o    (rdata_o)
    );
endmodule

// File: tb/link_id_reg_test.sv
module link_id_reg_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ready = 1'b0, cmd = 1'b0, lb = 1'b0;
    logic [5:0]  crate = '0;
    logic [1:0]  link = '0, muon = '0;
    logic [2:0]  dev = '0;
    logic [15:0] rdata;
    logic [7:0]  exp_id = '0;
    int checks = 0, failures = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    link_id_reg uut (
        .clk(clk), .rst_n(rst_n), .link_ready_i(ready), .reset_cmd_i(cmd),
        .crate_num_i(crate), .link_num_i(link), .loopback_i(lb),
        .muon_idx_i(muon), .dev_idx_i(dev), .rdata_o(rdata)
    );

    function automatic logic [15:0] expect_word(logic l, logic [1:0] m, logic [2:0] d, logic [7:0] id);
        return l ? {1'b1, 10'd0, d, m} : {8'd0, id};
    endfunction

    task automatic check(string tag, logic [15:0] exp);
        checks++;
        if (rdata !== exp) begin
            failures++;
            $display("FAIL %s: rdata=%h expected=%h", tag, rdata, exp);
        end
    endtask

    task automatic step(logic c, logic r, logic [5:0] cr, logic [1:0] lk,
                        logic l, logic [1:0] m, logic [2:0] d, string tag);
        @(negedge clk);
        cmd = c; ready = r; crate = cr; link = lk; lb = l; muon = m; dev = d;
        @(posedge clk);
        if (c && r) exp_id = {cr, lk};
        #5;
        check(tag, expect_word(l, m, d, exp_id));
    endtask

    initial begin
        #(20 * 5000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: rdata=%h expected=done", rdata);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(1234));
        #35 rst_n = 1'b1;
        #10 check("R1 reset", 16'h0000);
        step(1'b0, 1'b1, 6'd45, 2'd3, 1'b0, 2'd0, 3'd0, "R10 no cmd");
        step(1'b1, 1'b0, 6'd12, 2'd1, 1'b0, 2'd0, 3'd0, "R7 not ready");
        step(1'b1, 1'b1, 6'd63, 2'd3, 1'b0, 2'd0, 3'd0, "R2 R3 R4 R5 capture max");
        step(1'b0, 1'b0, 6'd0,  2'd0, 1'b0, 2'd0, 3'd0, "R10 hold");
        step(1'b1, 1'b1, 6'd21, 2'd2, 1'b0, 2'd0, 3'd0, "R8 overwrite");
        step(1'b1, 1'b0, 6'd5,  2'd1, 1'b0, 2'd0, 3'd0, "R7 refused");
        step(1'b0, 1'b1, 6'd9,  2'd0, 1'b1, 2'd3, 3'd5, "R6 loopback");
        step(1'b1, 1'b1, 6'd40, 2'd1, 1'b1, 2'd2, 3'd7, "R9 capture in loopback");
        step(1'b0, 1'b0, 6'd0,  2'd0, 1'b0, 2'd0, 3'd0, "R9 after loopback");
        step(1'b1, 1'b1, 6'd0,  2'd0, 1'b0, 2'd0, 3'd0, "R8 capture zero");
        for (int i = 0; i < 400; i++) begin
            logic c, r, l;
            c = ($urandom % 4) == 0;
            r = ($urandom % 3) != 0;
            l = ($urandom % 5) == 0;
            step(c, r, 6'($urandom), 2'($urandom), l, 2'($urandom), 3'($urandom),
                 l ? "R6 random" : "R3 R4 random");
        end
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule